// File: doc/BRIEF.md
# Host-Flagged Illegal Command Handler

This block sits beside a remote terminal's protocol engine and lets the attached host reject a valid command it cannot serve. The host raises an illegal-command line. The block decides whether that assertion counts for the command in progress. If it does, the block raises the message error bit for the outgoing status word, drives a message error pin and sets a sticky message error latch.

The time at which the line is judged depends on the kind of command. A set of mode codes is sampled once, very soon after the command strobe. Receive commands have a long window after the strobe, and an assertion inside it holds off DMA requests for as long as the line stays high. All other commands are judged in a window that opens when the status word starts. A broadcast sends no status word, so its window opens at the strobe and the block flags the status transmission as suppressed. All windows are given in nanoseconds and converted to clock cycles. The line passes through a two-stage synchronizer before any pulse-width measurement.

Top module: `illcmd_flag_ctrl`

## Requirements
- R1: After reset, me_bit_o, me_pin_o, me_latch_o, dma_sup_o and stat_sup_o are all 0.
- R2: For an ordinary command, a synchronized illegal pulse that stays high for at least MIN_PULSE cycles sets me_bit_o, me_pin_o and me_latch_o together. The pulse must be high at some cycle inside the STAT_WIN cycles after status_i rises.
- R3: An illegal assertion that begins after the status window has closed is ignored, and me_bit_o stays 0.
- R4: An illegal pulse shorter than MIN_PULSE cycles is ignored, and me_bit_o stays 0.
- R5: A command with mc_sel_i=1 and mcsa_i equal to 2, 4, 5, 6, 7 or 18 is judged only by the synchronized illegal level EARLY cycles after the strobe, with no width requirement. An assertion after that sample point is ignored, even if a status window opens.
- R6: For a receive command (rcv_i=1, xmit_i=0), dma_sup_o rises once the line is high within RX_WIN cycles of the strobe. It falls if the line drops before status_i rises. An assertion after RX_WIN cycles leaves dma_sup_o at 0.
- R7: For a receive command, if dma_sup_o is still high when status_i rises, the error is accepted at that rise, and dma_sup_o then stays high until the next strobe.
- R8: A strobe with bcast_i=1 sets stat_sup_o, and a strobe with bcast_i=0 clears it. For a broadcast, the status window opens at the strobe.
- R9: The next command strobe clears me_bit_o and me_pin_o. me_latch_o stays set until latch_clr_i is pulsed.
- R10: dma_sup_o never rises for a transmit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_strobe_i | input | 1 | One-cycle pulse marking a new valid command |
| status_i | input | 1 | High while the status word is being sent |
| xmit_i | input | 1 | Command is a transmit |
| rcv_i | input | 1 | Command is a receive |
| bcast_i | input | 1 | Command is a broadcast |
| mc_sel_i | input | 1 | 1 = mcsa_i holds a mode code, 0 = a subaddress |
| mcsa_i | input | 5 | Mode code or subaddress |
| ill_cmd_i | input | 1 | Asynchronous illegal-command line from the host |
| latch_clr_i | input | 1 | Clears the sticky error latch |
| me_bit_o | output | 1 | Message error bit for the status word |
| me_pin_o | output | 1 | Message error output pin |
| me_latch_o | output | 1 | Sticky message error latch |
| dma_sup_o | output | 1 | Suppresses DMA requests |
| stat_sup_o | output | 1 | Status word transmission suppressed (broadcast) |

## Verification
A level on ill_cmd_i reaches the synchronized line two edges later. A width-qualified pulse needs MIN_PULSE further edges, and the error registers load on the edge after that, so an ordinary accept appears about MIN_PULSE+3 cycles after the input rises. An early-class accept appears EARLY+1 edges after the strobe. dma_sup_o follows the line three edges late, and stat_sup_o changes one edge after the strobe. Each check is sampled at a falling edge, with several cycles of margin past the latest due edge. Negative checks wait well beyond the point where an accept would have appeared.

// File: rtl/illcmd_pkg.sv
package illcmd_pkg;
  localparam int unsigned MCSA_W = 5;

  typedef enum logic [1:0] {
    CLS_TX    = 2'd0,
    CLS_RX    = 2'd1,
    CLS_EARLY = 2'd2
  } cmd_cls_e;

  function automatic logic is_early_code(input logic [MCSA_W-1:0] code);
    return (code == 5'd2) || (code == 5'd4) || (code == 5'd5) ||
           (code == 5'd6) || (code == 5'd7) || (code == 5'd18);
  endfunction

  function automatic cmd_cls_e classify(input logic mc_sel, input logic [MCSA_W-1:0] code,
                                        input logic rcv, input logic xmit);
    if (mc_sel && is_early_code(code)) return CLS_EARLY;
    if (rcv && !xmit)                  return CLS_RX;
    return CLS_TX;
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ps);
    return (ns * 1000 + per_ps - 1) / per_ps;
  endfunction
endpackage

// File: rtl/illcmd_sync.sv
module illcmd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/illcmd_pulse_qual.sv
module illcmd_pulse_qual #(
  parameter int unsigned MIN_CYC = 250,
  localparam int unsigned CW = $clog2(MIN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic ok_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!lvl_i)                    cnt_q <= '0;
    else if (cnt_q != CW'(MIN_CYC))     cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = lvl_i && (cnt_q == CW'(MIN_CYC));

  p_ok_needs_lvl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_i |=> cnt_q == '0);
endmodule

// File: rtl/illcmd_win_timer.sv
module illcmd_win_timer #(
  parameter int unsigned LIMIT = 825,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          act_o,
  output logic [CW-1:0] cnt_o,
  output logic          open_o
);
  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q && cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o  = act_q;
  assign cnt_o  = cnt_q;
  assign open_o = act_q && (cnt_q < CW'(LIMIT));
endmodule

// File: rtl/illcmd_flag_ctrl.sv
module illcmd_flag_ctrl
  import illcmd_pkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned MIN_PULSE_NS = 1000,
  parameter int unsigned EARLY_NS    = 178,
  parameter int unsigned STAT_WIN_NS = 3300,
  parameter int unsigned RX_WIN_NS   = 18200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_strobe_i,
  input  logic              status_i,
  input  logic              xmit_i,
  input  logic              rcv_i,
  input  logic              bcast_i,
  input  logic              mc_sel_i,
  input  logic [MCSA_W-1:0] mcsa_i,
  input  logic              ill_cmd_i,
  input  logic              latch_clr_i,
  output logic              me_bit_o,
  output logic              me_pin_o,
  output logic              me_latch_o,
  output logic              dma_sup_o,
  output logic              stat_sup_o
);
  localparam int unsigned MIN_CYC   = ns_to_cyc(MIN_PULSE_NS, CLK_PS);
  localparam int unsigned EARLY_CYC = ns_to_cyc(EARLY_NS, CLK_PS);
  localparam int unsigned SWIN_CYC  = ns_to_cyc(STAT_WIN_NS, CLK_PS);
  localparam int unsigned RXWIN_CYC = ns_to_cyc(RX_WIN_NS, CLK_PS);
  localparam int unsigned CMD_LIM   = (RXWIN_CYC > EARLY_CYC) ? RXWIN_CYC : EARLY_CYC + 1;
  localparam int unsigned CCW       = $clog2(CMD_LIM + 1);
  localparam int unsigned SCW       = $clog2(SWIN_CYC + 1);

  logic           ill_s, ill_ok;
  logic           status_q, status_rise;
  logic           cmd_act, cmd_open_unused;
  logic [CCW-1:0] cmd_cnt;
  logic           s_act_unused, s_open;
  logic [SCW-1:0] s_cnt_unused;
  cmd_cls_e       cls_q;
  logic           armed_q, elig_q, stat_seen_q;
  logic           me_err_q, me_latch_q, dma_sup_q, stat_sup_q;
  logic           early_hit, ord_hit, rx_hit, accept, rx_open;

  illcmd_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(ill_cmd_i), .q_o(ill_s)
  );

  illcmd_pulse_qual #(.MIN_CYC(MIN_CYC)) u_qual (
    .clk_i, .rst_ni, .lvl_i(ill_s), .ok_o(ill_ok)
  );

  // Command-relative timer: early sample point and receive DMA window
  illcmd_win_timer #(.LIMIT(CMD_LIM)) u_cmd_tmr (
    .clk_i, .rst_ni,
    .start_i(cmd_strobe_i), .stop_i(1'b0),
    .act_o(cmd_act), .cnt_o(cmd_cnt), .open_o(cmd_open_unused)
  );

  // Status window: opens on status rise, or at the strobe for broadcasts
  illcmd_win_timer #(.LIMIT(SWIN_CYC)) u_stat_tmr (
    .clk_i, .rst_ni,
    .start_i(status_rise | (cmd_strobe_i & bcast_i)),
    .stop_i(cmd_strobe_i & ~bcast_i),
    .act_o(s_act_unused), .cnt_o(s_cnt_unused), .open_o(s_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b0;
    else         status_q <= status_i;
  end
  assign status_rise = status_i & ~status_q;

  assign rx_open   = cmd_act && (cmd_cnt < CCW'(RXWIN_CYC));
  assign early_hit = (cls_q == CLS_EARLY) && cmd_act && (cmd_cnt == CCW'(EARLY_CYC)) && ill_s;
  assign ord_hit   = (cls_q != CLS_EARLY) && ill_ok && (elig_q || s_open);
  assign rx_hit    = (cls_q == CLS_RX) && status_rise && dma_sup_q;
  assign accept    = armed_q && !cmd_strobe_i && (early_hit || ord_hit || rx_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q       <= CLS_TX;
      armed_q     <= 1'b0;
      elig_q      <= 1'b0;
      stat_seen_q <= 1'b0;
      me_err_q    <= 1'b0;
      dma_sup_q   <= 1'b0;
      stat_sup_q  <= 1'b0;
    end else if (cmd_strobe_i) begin
      cls_q       <= classify(mc_sel_i, mcsa_i, rcv_i, xmit_i);
      armed_q     <= 1'b1;
      elig_q      <= 1'b0;
      stat_seen_q <= 1'b0;
      me_err_q    <= 1'b0;
      dma_sup_q   <= 1'b0;
      stat_sup_q  <= bcast_i;
    end else begin
      elig_q <= ill_s && (elig_q || s_open);
      if (status_rise) stat_seen_q <= 1'b1;
      if (accept) begin
        armed_q  <= 1'b0;
        me_err_q <= 1'b1;
      end
      if (cls_q == CLS_RX && !stat_seen_q) begin
        if (ill_s && rx_open) dma_sup_q <= 1'b1;
        else if (!ill_s)      dma_sup_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          me_latch_q <= 1'b0;
    else if (accept)      me_latch_q <= 1'b1;
    else if (latch_clr_i) me_latch_q <= 1'b0;
  end

  assign me_bit_o   = me_err_q;
  assign me_pin_o   = me_err_q;
  assign me_latch_o = me_latch_q;
  assign dma_sup_o  = dma_sup_q;
  assign stat_sup_o = stat_sup_q;

  p_latch_with_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(me_err_q) |-> me_latch_q);
  p_bit_clr_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_i |=> !me_err_q);
  p_latch_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    me_latch_q && !latch_clr_i |=> me_latch_q);
  p_dma_rx_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_sup_q |-> cls_q == CLS_RX);
  p_stat_sup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_i && bcast_i |=> stat_sup_q);
  p_dma_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_sup_q && stat_seen_q && !cmd_strobe_i |=> dma_sup_q);
  p_early_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_q == CLS_EARLY && !armed_q && !cmd_strobe_i |=> $stable(me_err_q));
endmodule

// File: tb/illcmd_flag_ctrl_tb_top.sv
module illcmd_flag_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_strobe_i = 1'b0, status_i = 1'b0, xmit_i = 1'b0, rcv_i = 1'b0;
  logic       bcast_i = 1'b0, mc_sel_i = 1'b0, ill_cmd_i = 1'b0, latch_clr_i = 1'b0;
  logic [4:0] mcsa_i = '0;
  logic       me_bit_o, me_pin_o, me_latch_o, dma_sup_o, stat_sup_o;
  int         n_chk = 0, n_err = 0;

  // 4 ns clock: MIN=8, EARLY=6, STAT_WIN=20, RX_WIN=40 cycles
  always #2 clk_i = ~clk_i;

  illcmd_flag_ctrl #(
    .CLK_PS(4000), .MIN_PULSE_NS(32), .EARLY_NS(24), .STAT_WIN_NS(80), .RX_WIN_NS(160)
  ) dut_i (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_cmd(input logic x, input logic r, input logic b, input logic mc,
                          input logic [4:0] code);
    @(negedge clk_i);
    xmit_i = x; rcv_i = r; bcast_i = b; mc_sel_i = mc; mcsa_i = code;
    cmd_strobe_i = 1'b1;
    @(negedge clk_i);
    cmd_strobe_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 me_bit", me_bit_o, 1'b0);
    check("R1 me_pin", me_pin_o, 1'b0);
    check("R1 latch", me_latch_o, 1'b0);
    check("R1 dma", dma_sup_o, 1'b0);
    check("R1 stat_sup", stat_sup_o, 1'b0);
  endtask

  task automatic t_ordinary;
    send_cmd(1, 0, 0, 0, 5'd1);
    cyc(5); status_i = 1'b1;
    cyc(3); ill_cmd_i = 1'b1;
    cyc(18);
    check("R2 me_bit", me_bit_o, 1'b1);
    check("R2 me_pin", me_pin_o, 1'b1);
    check("R2 latch", me_latch_o, 1'b1);
    check("R10 dma on transmit", dma_sup_o, 1'b0);
    ill_cmd_i = 1'b0; status_i = 1'b0;
    cyc(4);
  endtask

  task automatic t_late;
    send_cmd(1, 0, 0, 0, 5'd3);
    cyc(1);
    check("R9 bit cleared by strobe", me_bit_o, 1'b0);
    check("R9 pin cleared by strobe", me_pin_o, 1'b0);
    check("R9 latch kept", me_latch_o, 1'b1);
    status_i = 1'b1;
    cyc(30); ill_cmd_i = 1'b1;
    cyc(20);
    check("R3 late assertion", me_bit_o, 1'b0);
    ill_cmd_i = 1'b0; status_i = 1'b0;
    cyc(3);
    latch_clr_i = 1'b1; cyc(1); latch_clr_i = 1'b0;
    check("R9 latch cleared", me_latch_o, 1'b0);
  endtask

  task automatic t_short;
    send_cmd(1, 0, 0, 0, 5'd9);
    cyc(2); status_i = 1'b1;
    cyc(2); ill_cmd_i = 1'b1;
    cyc(4); ill_cmd_i = 1'b0;
    cyc(16);
    check("R4 short pulse", me_bit_o, 1'b0);
    check("R4 short pulse latch", me_latch_o, 1'b0);
    status_i = 1'b0;
    cyc(3);
  endtask

  task automatic t_early;
    @(negedge clk_i); ill_cmd_i = 1'b1;
    send_cmd(0, 0, 0, 1, 5'd18);
    cyc(8);
    check("R5 early sample code 18", me_bit_o, 1'b1);
    ill_cmd_i = 1'b0;
    cyc(3);
    send_cmd(0, 0, 0, 1, 5'd4);
    cyc(12); ill_cmd_i = 1'b1; status_i = 1'b1;
    cyc(20);
    check("R5 after sample point", me_bit_o, 1'b0);
    ill_cmd_i = 1'b0; status_i = 1'b0;
    cyc(3);
  endtask

  task automatic t_rx_drop;
    send_cmd(0, 1, 0, 0, 5'd2);
    cyc(5); ill_cmd_i = 1'b1;
    cyc(6);
    check("R6 dma raised", dma_sup_o, 1'b1);
    ill_cmd_i = 1'b0;
    cyc(5);
    check("R6 dma dropped", dma_sup_o, 1'b0);
    status_i = 1'b1;
    cyc(3);
    check("R6 no error after drop", me_bit_o, 1'b0);
    status_i = 1'b0;
    send_cmd(0, 1, 0, 0, 5'd2);
    cyc(50); ill_cmd_i = 1'b1;
    cyc(8);
    check("R6 outside rx window", dma_sup_o, 1'b0);
    ill_cmd_i = 1'b0;
    cyc(3);
  endtask

  task automatic t_rx_hold;
    send_cmd(0, 1, 0, 0, 5'd6);
    cyc(5); ill_cmd_i = 1'b1;
    cyc(30);
    check("R7 no error before status", me_bit_o, 1'b0);
    check("R7 dma held", dma_sup_o, 1'b1);
    status_i = 1'b1;
    cyc(3);
    check("R7 error at status", me_bit_o, 1'b1);
    ill_cmd_i = 1'b0;
    cyc(5);
    check("R7 dma kept after status", dma_sup_o, 1'b1);
    status_i = 1'b0;
    send_cmd(1, 0, 0, 0, 5'd1);
    cyc(1);
    check("R7 dma cleared by strobe", dma_sup_o, 1'b0);
    latch_clr_i = 1'b1; cyc(1); latch_clr_i = 1'b0;
  endtask

  task automatic t_bcast;
    send_cmd(0, 1, 1, 0, 5'd8);
    cyc(1);
    check("R8 stat_sup set", stat_sup_o, 1'b1);
    cyc(2); ill_cmd_i = 1'b1;
    cyc(15);
    check("R8 broadcast accepted without status", me_bit_o, 1'b1);
    ill_cmd_i = 1'b0;
    cyc(3);
    send_cmd(1, 0, 0, 0, 5'd1);
    cyc(1);
    check("R8 stat_sup cleared", stat_sup_o, 1'b0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_ordinary();
    t_late();
    t_short();
    t_early();
    t_rx_drop();
    t_rx_hold();
    t_bcast();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule